// File: doc/BRIEF.md
# Programmable Interrupt-Output Waveform Timer

This block drives one external output pin from a timebase derived from the bus clock. Software writes a single 32-bit control word. The word holds a 16-bit period count, a 3-bit mode selector and a timebase-select bit. In square-wave mode the pin inverts every COUNT+1 ticks, so a full cycle lasts 2*(COUNT+1) ticks.

A tick is normally 520 bus clocks. Bit 31 of the control word reads back the live output level. Software can therefore time the square wave against a known reference and work out the bus clock frequency. Setting the timebase-select bit bypasses the prescaler, so one tick equals one bus clock.

The pin is driven only while two bits of a separate pin-control register are both set: the output-enable bit and the direction bit. Every inversion of the output sets an event latch that feeds an interrupt status word. The latch stays set until it is cleared. Every mode except square-wave holds the output low.

Top module: `wave_timer`

## Requirements
- R1: After reset the control read word is 0, `pinOut` and `pinOe` are 0, and `rtEvent` is 0.
- R2: The control word holds the period count in bits 15:0, the mode in bits 18:16 and the timebase-select bit at bit 30. The read word returns these fields as last written. Bits 29:19 always read 0, whatever was written there.
- R3: With mode 7 and timebase-select set, the output first goes high COUNT+1 clocks after the write edge. After that it inverts every COUNT+1 clocks.
- R4: With mode 7 and timebase-select clear, one tick lasts 520 clocks. The output first goes high (COUNT+1)*520 clocks after the write edge.
- R5: Bit 31 of the read word equals the present output level, with no extra delay relative to the pin.
- R6: `pinOe` is 1 only when `pinEnable` and `pinDirOut` are both 1. `pinOut` carries the output level under that condition and is 0 otherwise. The output level keeps running while the pin is gated.
- R7: Any write to the control word clears the prescaler and the tick counter and forces the output low. The new period is then timed from that write.
- R8: Writing an all-zero word returns the timer to its power-on state. The output is low and stays low.
- R9: Mode values other than 7 hold the output low and leave the counters idle.
- R10: Each output inversion sets `rtEvent`. The flag stays set until `evtClr` is high at a clock edge with no inversion. When an inversion and `evtClr` fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Write strobe for the control word |
| ctlWrData | input | 32 | Control word write data |
| ctlRdData | output | 32 | Control word read data, with the live output at bit 31 |
| pinEnable | input | 1 | Output-enable bit from the pin-control register |
| pinDirOut | input | 1 | Direction bit of the output pin (1 = output) |
| evtClr | input | 1 | Clears the event latch |
| pinOut | output | 1 | Gated output level toward the pad |
| pinOe | output | 1 | Pad output enable |
| rtEvent | output | 1 | Latched output-section event flag |

## Verification
A prescaler or tick counter that is off by one moves the first edge of bit 31 by one clock in diagnostic timebase, or by 520 clocks in normal timebase. The bench therefore samples the edge exactly one clock before and at the expected cycle. A restart that fails to clear the counters makes the first edge after a rewrite arrive early, and this shows within COUNT+1 ticks. A stale output register or a wrong mode decode leaves bit 31 high right after a write, or lets it move in an idle mode; this shows on the first sampled cycle. An event latch that loses its set-over-clear priority clears in the cycle of an inversion, and this is checked in that cycle.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;

  // Field geometry of the control word; the read path and the
  // write decode both depend on these positions.
  localparam int WORD_W    = 32;
  localparam int CNT_W     = 16;
  localparam int MODE_W    = 3;
  localparam int MODE_LSB  = 16;
  localparam int DIAG_BIT  = 30;
  localparam int LEVEL_BIT = 31;

  // Mode encoding: only square-wave is active.
  localparam logic [MODE_W-1:0] MODE_IDLE   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_SQUARE = 3'd7;

  // Strobes from control to datapath.
  typedef struct packed {
    logic restart;   // control word written this cycle
    logic run;       // square-wave mode selected
    logic fastTick;  // prescaler bypassed
  } ctl_strobe_t;

endpackage

// File: rtl/wave_timer_ctrl.sv
module wave_timer_ctrl
  import wave_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrCount,
  input  logic [MODE_W-1:0] wrMode,
  input  logic              wrDiag,
  input  logic              outLevel,
  output ctl_strobe_t       strb,
  output logic [CNT_W-1:0]  periodCnt,
  output logic [WORD_W-1:0] rdData
);

  localparam int RSV_LO = MODE_LSB + MODE_W;
  localparam int RSV_W  = DIAG_BIT - RSV_LO;

  logic [CNT_W-1:0]  countReg;
  logic [MODE_W-1:0] modeReg;
  logic              diagReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
      modeReg  <= MODE_IDLE;
      diagReg  <= 1'b0;
    end else if (wrEn) begin
      countReg <= wrCount;
      modeReg  <= wrMode;
      diagReg  <= wrDiag;
    end
  end

  always_comb begin
    strb.restart  = wrEn;
    strb.run      = (modeReg == MODE_SQUARE);
    strb.fastTick = diagReg;
  end

  assign periodCnt = countReg;

  // Read word: live level, timebase bit, zero-filled reserved span, fields.
  assign rdData = {outLevel, diagReg, {RSV_W{1'b0}}, modeReg, countReg};

endmodule

// File: rtl/wave_timer_dp.sv
module wave_timer_dp
  import wave_timer_pkg::*;
#(
  parameter int PRESCALE = 520
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      strb,
  input  logic [CNT_W-1:0] periodCnt,
  input  logic             evtClr,
  output logic             outLevel,
  output logic             rtEvent
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] tickCnt;
  logic             tick;
  logic             sectionEnd;

  assign tick       = strb.run && (strb.fastTick || (preCnt == PRE_LAST));
  assign sectionEnd = tick && (tickCnt == periodCnt) && !strb.restart;

  // Prescaler: bus clocks into ticks.
  always_ff @(posedge clk) begin
    if (!rstN || strb.restart || !strb.run || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // Tick counter and output level.
  always_ff @(posedge clk) begin
    if (!rstN || strb.restart || !strb.run) begin
      tickCnt  <= '0;
      outLevel <= 1'b0;
    end else if (tick) begin
      if (tickCnt == periodCnt) begin
        tickCnt  <= '0;
        outLevel <= ~outLevel;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  // Event latch: set has priority over clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtEvent <= 1'b0;
    end else if (sectionEnd) begin
      rtEvent <= 1'b1;
    end else if (evtClr) begin
      rtEvent <= 1'b0;
    end
  end

endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wave_timer_pkg::*;
#(
  parameter int PRESCALE = 520
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [WORD_W-1:0] ctlWrData,
  output logic [WORD_W-1:0] ctlRdData,
  input  logic              pinEnable,
  input  logic              pinDirOut,
  input  logic              evtClr,
  output logic              pinOut,
  output logic              pinOe,
  output logic              rtEvent
);

  ctl_strobe_t      strb;
  logic [CNT_W-1:0] periodCnt;
  logic             outLevel;

  wave_timer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (ctlWrEn),
    .wrCount   (ctlWrData[CNT_W-1:0]),
    .wrMode    (ctlWrData[MODE_LSB+MODE_W-1:MODE_LSB]),
    .wrDiag    (ctlWrData[DIAG_BIT]),
    .outLevel  (outLevel),
    .strb      (strb),
    .periodCnt (periodCnt),
    .rdData    (ctlRdData)
  );

  wave_timer_dp #(.PRESCALE(PRESCALE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .periodCnt (periodCnt),
    .evtClr    (evtClr),
    .outLevel  (outLevel),
    .rtEvent   (rtEvent)
  );

  assign pinOe  = pinEnable & pinDirOut;
  assign pinOut = pinOe & outLevel;

endmodule

// File: rtl/wave_timer_chk.sv
module wave_timer_chk
  import wave_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ctlWrEn,
  input logic [WORD_W-1:0] ctlWrData,
  input logic [WORD_W-1:0] ctlRdData,
  input logic              pinEnable,
  input logic              pinDirOut,
  input logic              evtClr,
  input logic              pinOut,
  input logic              pinOe,
  input logic              rtEvent
);

  localparam logic [WORD_W-2:0] RW_MASK = 31'h4007_FFFF;

  // R2: fields read back as written, reserved bits zero
  a_r2_field_readback: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> (ctlRdData[WORD_W-2:0] == ($past(ctlWrData[WORD_W-2:0]) & RW_MASK)));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[DIAG_BIT-1:MODE_LSB+MODE_W] == '0);

  // R7: a write forces the output low, whatever bit 31 carried
  a_r7_write_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[LEVEL_BIT]) |=> !ctlRdData[LEVEL_BIT]);

  // R9: non-square modes keep the output low
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRdData[MODE_LSB+MODE_W-1:MODE_LSB] != MODE_SQUARE) |-> !ctlRdData[LEVEL_BIT]);

  // R6: pin silent when gated, follows the level when open
  a_r6_pin_gated: assert property (@(posedge clk) disable iff (!rstN)
    !(pinEnable && pinDirOut) |-> (!pinOut && !pinOe));

  // R5: read-back level matches the driven pin
  a_r5_level_matches_pin: assert property (@(posedge clk) disable iff (!rstN)
    (pinEnable && pinDirOut) |-> (pinOut == ctlRdData[LEVEL_BIT]));

  // R10: an inversion always leaves the event latch set
  a_r10_rise_sets_event: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlRdData[LEVEL_BIT]) |-> rtEvent);

  a_r10_event_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rtEvent && !evtClr) |=> rtEvent);

endmodule

bind wave_timer wave_timer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctlWrEn   (ctlWrEn),
  .ctlWrData (ctlWrData),
  .ctlRdData (ctlRdData),
  .pinEnable (pinEnable),
  .pinDirOut (pinDirOut),
  .evtClr    (evtClr),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .rtEvent   (rtEvent)
);

// File: tb/tb_wave_timer.sv
`timescale 1ns/1ps
module tb_wave_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [31:0] ctlWrData = '0;
  logic [31:0] ctlRdData;
  logic        pinEnable = 1'b0;
  logic        pinDirOut = 1'b0;
  logic        evtClr = 1'b0;
  logic        pinOut;
  logic        pinOe;
  logic        rtEvent;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk; // 125 MHz

  wave_timer dut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .pinEnable(pinEnable), .pinDirOut(pinDirOut),
    .evtClr(evtClr), .pinOut(pinOut), .pinOe(pinOe), .rtEvent(rtEvent)
  );

  localparam logic [31:0] SQ = 32'h0007_0000;
  localparam logic [31:0] DG = 32'h4000_0000;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Returns at the falling edge after the write edge.
  task automatic writeCtl(input logic [31:0] w);
    @(negedge clk);
    ctlWrEn = 1'b1;
    ctlWrData = w;
    @(posedge clk);
    @(negedge clk);
    ctlWrEn = 1'b0;
    ctlWrData = '0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] lvl();
    return {31'd0, ctlRdData[31]};
  endfunction

  task automatic testReset();
    check("R1 read word", ctlRdData, 32'h0);
    check("R1 pin", {30'd0, pinOe, pinOut}, 32'h0);
    check("R1 event", {31'd0, rtEvent}, 32'h0);
  endtask

  task automatic testFields();
    writeCtl(32'hFFFF_FFFF);
    check("R2 reserved masked", ctlRdData, 32'h4007_FFFF);
    writeCtl(32'h0003_1234);
    check("R2 fields", ctlRdData, 32'h0003_1234);
  endtask

  task automatic testDiagSquare();
    pinEnable = 1'b1; pinDirOut = 1'b1;
    writeCtl(SQ | DG | 32'd4);
    waitCyc(4);
    check("R3 before first edge", lvl(), 32'd0);
    waitCyc(1);
    check("R3 first edge", lvl(), 32'd1);
    check("R5 pin equals readback", {31'd0, pinOut}, 32'd1);
    waitCyc(4);
    check("R3 half period hold", lvl(), 32'd1);
    waitCyc(1);
    check("R3 second edge", lvl(), 32'd0);
  endtask

  task automatic testGate();
    pinEnable = 1'b0; pinDirOut = 1'b1;
    writeCtl(SQ | DG | 32'd0);
    waitCyc(1);
    check("R6 level runs while gated", lvl(), 32'd1);
    check("R6 pin off enable low", {30'd0, pinOe, pinOut}, 32'd0);
    pinEnable = 1'b1; pinDirOut = 1'b0;
    waitCyc(2);
    check("R6 pin off dir input", {30'd0, pinOe, pinOut}, 32'd0);
    pinDirOut = 1'b1;
    #1;
    check("R6 pin open", {30'd0, pinOe, pinOut}, {30'd0, 1'b1, ctlRdData[31]});
  endtask

  task automatic testRestart();
    writeCtl(SQ | DG | 32'd5);
    waitCyc(6);
    check("R7 setup high", lvl(), 32'd1);
    waitCyc(2);
    writeCtl(SQ | DG | 32'd5);
    check("R7 low after write", lvl(), 32'd0);
    waitCyc(5);
    check("R7 fresh period hold", lvl(), 32'd0);
    waitCyc(1);
    check("R7 fresh period edge", lvl(), 32'd1);
  endtask

  task automatic testZeroWrite();
    writeCtl(SQ | DG | 32'd0);
    waitCyc(1);
    writeCtl(32'h0);
    check("R8 zero word", ctlRdData, 32'h0);
    waitCyc(10);
    check("R8 stays low", {31'd0, pinOut}, 32'd0);
  endtask

  task automatic testIdleMode();
    evtClr = 1'b1; waitCyc(1); evtClr = 1'b0;
    writeCtl(32'h0003_0000 | DG);
    waitCyc(20);
    check("R9 mode 3 low", {31'd0, ctlRdData[31]}, 32'd0);
    check("R9 no event", {31'd0, rtEvent}, 32'd0);
    writeCtl(32'h0006_0000);
    waitCyc(20);
    check("R9 mode 6 low", {31'd0, pinOut}, 32'd0);
  endtask

  task automatic testEvent();
    writeCtl(SQ | DG | 32'd3);
    waitCyc(3);
    evtClr = 1'b1;
    waitCyc(1);
    check("R10 set wins over clear", {31'd0, rtEvent}, 32'd1);
    waitCyc(1);
    check("R10 clear with no edge", {31'd0, rtEvent}, 32'd0);
    evtClr = 1'b0;
    waitCyc(3);
    check("R10 set on next edge", {31'd0, rtEvent}, 32'd1);
    waitCyc(6);
    check("R10 held without clear", {31'd0, rtEvent}, 32'd1);
  endtask

  task automatic testPrescale();
    writeCtl(SQ | 32'd1);
    waitCyc(1039);
    check("R4 before 1040 clocks", lvl(), 32'd0);
    waitCyc(1);
    check("R4 edge at 1040 clocks", lvl(), 32'd1);
    waitCyc(1039);
    check("R4 hold second half", lvl(), 32'd1);
    waitCyc(1);
    check("R4 second edge", lvl(), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    waitCyc(1);
    testReset();
    testFields();
    testDiagSquare();
    testGate();
    testRestart();
    testZeroWrite();
    testIdleMode();
    testEvent();
    testPrescale();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule